// File: doc/BRIEF.md
# DMA Bus Watchpoint Comparator

This block is a debug monitor that sits beside an internal DMA bus. It looks at every transfer on that bus. When the comparator is armed, it checks each transfer against a programmed address, a programmed direction (read or write) and a programmed transfer kind (burst or single). If all three agree, a sticky hit flag is set. Software clears the flag by writing one to it. The hit can also drive a level-sensitive hardware-error interrupt line, under a separate enable bit. The upper half of the control word holds a 16-bit count of the bus operations seen while the comparator is enabled. The count stops at its maximum, and software can both read and write it.

Software reaches the block through a simple register port with two words. One is the control/status word and the other is the address word. The snoop side takes a valid strobe, the address, a read flag and a burst flag each cycle. The hit flag is held by a three-state machine:

- `ST_OFF`: comparator disabled, no hit.
- `ST_ARMED`: comparator enabled, no hit.
- `ST_HIT`: hit latched.

The machine has these transitions:

- *match*: any state goes to `ST_HIT`.
- *arm*: `ST_OFF` goes to `ST_ARMED` when the enable bit is 1.
- *disarm*: `ST_ARMED` goes to `ST_OFF` when the enable bit is 0.
- *clear*: `ST_HIT` goes to `ST_ARMED` or `ST_OFF`, according to the enable bit, on a write-one-to-clear that has no match in the same cycle.
- *hold*: `ST_HIT` stays in `ST_HIT` otherwise.

Top module: `dma_watch_cmp`

## Requirements
- R1: After reset, the control word (reg_sel=0) and the address word (reg_sel=1) both read 0, and hwe_irq is 0.
- R2: The hit flag reads 1 on control bit 4 the cycle after a matching transfer. A matching transfer needs all of the following in the same cycle:
  - snoop_valid is 1.
  - The enable bit (bit 0) is 1.
  - The address equals the address word.
  - The direction matches bit 1.
  - The burst kind matches bit 2.
- R3: Direction select, control bit 1: 0 matches only writes (snoop_read=0) and 1 matches only reads (snoop_read=1).
- R4: Burst select, control bit 2: 0 matches only bursts (snoop_burst=1) and 1 matches only single transfers (snoop_burst=0).
- R5: With the enable bit at 0, no transfer sets the hit flag and the count does not change.
- R6: Writing the control word with bit 4 at 1 clears the hit flag. Writing it with bit 4 at 0 leaves the hit flag unchanged.
- R7: If a match and a clear of the hit flag occur in the same cycle, the hit flag reads 1 afterwards.
- R8: hwe_irq is 1 exactly when the hit flag is 1 and the interrupt enable (bit 3) is 1. It falls when the hit is cleared.
- R9: Each transfer with snoop_valid=1 while enabled adds 1 to the count (bits 31:16). The count stays at 0xFFFF once it reaches that value.
- R10: A control write loads bits 31:16 into the count, and the count reads back with the written value.
- R11: The address word reads back as written. The compare is an exact full-width equality. Cycles with snoop_valid=0 neither match nor count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 control/status, 1 address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| snoop_valid | input | 1 | A DMA bus transfer is present this cycle |
| snoop_addr | input | AW | Transfer address |
| snoop_read | input | 1 | 1 read, 0 write |
| snoop_burst | input | 1 | 1 burst, 0 single |
| hwe_irq | output | 1 | Hardware-error interrupt, level |

## Verification
Register writes and snoop transfers are captured on one clock edge. The hit flag, the count and the interrupt all change on that same edge, so each result is due one cycle after its stimulus. Read data is a combinational view of the registers. The bench therefore drives every stimulus on a falling edge, lets exactly one rising edge pass, and samples on the following falling edge. The check for a transfer that must be ignored reads the hit flag, the count and the interrupt at that same point, before the next stimulus is applied.

// File: rtl/dwc_pkg.sv
package dwc_pkg;
    localparam int REG_W = 32;
    localparam int CNT_W = 16;
    localparam int CNT_LSB = REG_W - CNT_W;

    // control word bit positions
    localparam int B_EN  = 0;
    localparam int B_DIR = 1;
    localparam int B_NB  = 2;
    localparam int B_IE  = 3;
    localparam int B_HIT = 4;

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_ADDR = 1'b1
    } reg_sel_t;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ARMED = 2'd1,
        ST_HIT   = 2'd2
    } hit_state_t;

    typedef struct packed {
        logic en;
        logic dir_rd;
        logic nonburst;
        logic irq_en;
    } ctrl_t;
endpackage

// File: rtl/dwc_regs.sv
module dwc_regs
    import dwc_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              snoop_valid,
    output ctrl_t             ctrl,
    output logic [AW-1:0]     addr_cmp,
    output logic [CNT_W-1:0]  count,
    output logic              clr_req
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic wr_ctrl;
    logic wr_addr;
    logic cnt_step;

    assign wr_ctrl  = reg_wr && (reg_sel == SEL_CTRL);
    assign wr_addr  = reg_wr && (reg_sel == SEL_ADDR);
    assign clr_req  = wr_ctrl && reg_wdata[B_HIT];
    assign cnt_step = snoop_valid && ctrl.en && (count != CNT_MAX);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl     <= '0;
            addr_cmp <= '0;
            count    <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl.en       <= reg_wdata[B_EN];
                ctrl.dir_rd   <= reg_wdata[B_DIR];
                ctrl.nonburst <= reg_wdata[B_NB];
                ctrl.irq_en   <= reg_wdata[B_IE];
                count         <= reg_wdata[REG_W-1:CNT_LSB];
            end else if (cnt_step) begin
                count <= count + 1'b1;
            end
            if (wr_addr) begin
                addr_cmp <= reg_wdata[AW-1:0];
            end
        end
    end

    AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_MAX && !wr_ctrl) |=> (count == CNT_MAX)); // R9
    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.en && !wr_ctrl) |=> $stable(count)); // R5
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_valid && ctrl.en && !wr_ctrl && count != CNT_MAX)
        |=> (count == $past(count) + 1'b1)); // R9
endmodule

// File: rtl/dwc_match.sv
module dwc_match
    import dwc_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ctrl_t         ctrl,
    input  logic [AW-1:0] addr_cmp,
    input  logic          snoop_valid,
    input  logic [AW-1:0] snoop_addr,
    input  logic          snoop_read,
    input  logic          snoop_burst,
    output logic          match
);
    logic addr_eq;
    logic dir_eq;
    logic kind_eq;

    always_comb begin
        addr_eq = (snoop_addr == addr_cmp);
        dir_eq  = (snoop_read == ctrl.dir_rd);
        kind_eq = (snoop_burst != ctrl.nonburst);
        match   = snoop_valid && ctrl.en && addr_eq && dir_eq && kind_eq;
    end

    AST_NO_MATCH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl.en && snoop_valid) |-> !match); // R5
    AST_MATCH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> (snoop_addr == addr_cmp)); // R11
endmodule

// File: rtl/dwc_fsm.sv
module dwc_fsm
    import dwc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic match,
    input  logic clr_req,
    output logic hit
);
    hit_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF: begin
                if (match)       state_nx = ST_HIT;
                else if (enable) state_nx = ST_ARMED;
            end
            ST_ARMED: begin
                if (match)        state_nx = ST_HIT;
                else if (!enable) state_nx = ST_OFF;
            end
            ST_HIT: begin
                if (match)        state_nx = ST_HIT;
                else if (clr_req) state_nx = enable ? ST_ARMED : ST_OFF;
            end
            default: state_nx = ST_OFF;
        endcase
    end

    always_comb begin
        hit = (state == ST_HIT);
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> hit); // R7
    AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && clr_req && !match) |=> !hit); // R6
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !clr_req) |=> hit); // R6
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && !match) |=> !hit); // R5
endmodule

// File: rtl/dma_watch_cmp.sv
module dma_watch_cmp
    import dwc_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             snoop_valid,
    input  logic [AW-1:0]    snoop_addr,
    input  logic             snoop_read,
    input  logic             snoop_burst,
    output logic             hwe_irq
);
    localparam int PAD_W = REG_W - AW;

    ctrl_t            ctrl;
    logic [AW-1:0]    addr_cmp;
    logic [CNT_W-1:0] count;
    logic             clr_req;
    logic             match;
    logic             hit;

    dwc_regs #(.AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .snoop_valid(snoop_valid), .ctrl(ctrl),
        .addr_cmp(addr_cmp), .count(count), .clr_req(clr_req)
    );

    dwc_match #(.AW(AW)) u_match (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .addr_cmp(addr_cmp),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
        .snoop_read(snoop_read), .snoop_burst(snoop_burst), .match(match)
    );

    dwc_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .enable(ctrl.en), .match(match),
        .clr_req(clr_req), .hit(hit)
    );

    always_comb begin
        if (reg_sel == SEL_ADDR) begin
            if (PAD_W > 0) reg_rdata = {{PAD_W{1'b0}}, addr_cmp};
            else           reg_rdata = addr_cmp;
        end else begin
            reg_rdata = '0;
            reg_rdata[REG_W-1:CNT_LSB] = count;
            reg_rdata[B_HIT] = hit;
            reg_rdata[B_IE]  = ctrl.irq_en;
            reg_rdata[B_NB]  = ctrl.nonburst;
            reg_rdata[B_DIR] = ctrl.dir_rd;
            reg_rdata[B_EN]  = ctrl.en;
        end
        hwe_irq = hit && ctrl.irq_en;
    end

    AST_IRQ_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        hwe_irq |-> (reg_sel == SEL_ADDR || reg_rdata[B_HIT])); // R8
endmodule

// File: tb/dma_watch_cmp_bench.sv
module dma_watch_cmp_bench;
    localparam int AW = 32;
    localparam logic [31:0] EN = 32'h1, DIR = 32'h2, NB = 32'h4, IE = 32'h8, HIT = 32'h10;
    localparam logic [31:0] A0 = 32'hA5A5_1234;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic snoop_valid = 1'b0;
    logic [AW-1:0] snoop_addr = '0;
    logic snoop_read = 1'b0;
    logic snoop_burst = 1'b0;
    logic hwe_irq;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] exp_cnt = '0;

    always #10 clk = ~clk;

    dma_watch_cmp #(.AW(AW)) u_dma_watch_cmp (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .snoop_valid(snoop_valid),
        .snoop_addr(snoop_addr), .snoop_read(snoop_read), .snoop_burst(snoop_burst),
        .hwe_irq(hwe_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // stimulus on a falling edge, one rising edge, back at the falling edge
    task automatic step();
        @(negedge clk);
        reg_wr = 1'b0;
        snoop_valid = 1'b0;
    endtask

    task automatic wr_ctrl(input logic [31:0] d);
        reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = d;
        exp_cnt = d[31:16];
        step();
    endtask

    task automatic bus_op(input logic [31:0] a, input logic rd, input logic bu);
        snoop_valid = 1'b1; snoop_addr = a; snoop_read = rd; snoop_burst = bu;
        step();
    endtask

    function automatic logic hit_now();
        return reg_rdata[4];
    endfunction

    task automatic read_ctrl();
        reg_sel = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        read_ctrl();
        chk("R1 ctrl", reg_rdata, 32'h0);
        chk("R1 irq", {31'b0, hwe_irq}, 32'h0);
        reg_sel = 1'b1; #1;
        chk("R1 addr", reg_rdata, 32'h0);
    endtask

    task automatic t_regs();
        reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = A0;
        step();
        reg_sel = 1'b1; #1;
        chk("R11 addr readback", reg_rdata, A0);
        wr_ctrl(32'h1234_0000);
        read_ctrl();
        chk("R10 count write", reg_rdata, 32'h1234_0000);
    endtask

    task automatic t_basic();
        wr_ctrl(EN);
        bus_op(A0, 1'b0, 1'b1);
        exp_cnt++;
        read_ctrl();
        chk("R2 hit on match", {31'b0, hit_now()}, 32'h1);
        chk("R9 count inc", {16'b0, reg_rdata[31:16]}, {16'b0, exp_cnt});
        chk("R8 irq masked", {31'b0, hwe_irq}, 32'h0);
    endtask

    task automatic t_w1c();
        wr_ctrl(EN | {exp_cnt, 16'h0});
        read_ctrl();
        chk("R6 write 0 keeps hit", {31'b0, hit_now()}, 32'h1);
        wr_ctrl(EN | HIT | {exp_cnt, 16'h0});
        read_ctrl();
        chk("R6 write 1 clears hit", {31'b0, hit_now()}, 32'h0);
    endtask

    task automatic t_dir();
        bus_op(A0, 1'b1, 1'b1);
        exp_cnt++;
        read_ctrl();
        chk("R3 read ignored when dir=0", {31'b0, hit_now()}, 32'h0);
        chk("R9 count on nonmatch", {16'b0, reg_rdata[31:16]}, {16'b0, exp_cnt});
        wr_ctrl(EN | DIR | {exp_cnt, 16'h0});
        bus_op(A0, 1'b0, 1'b1);
        exp_cnt++;
        read_ctrl();
        chk("R3 write ignored when dir=1", {31'b0, hit_now()}, 32'h0);
        bus_op(A0, 1'b1, 1'b1);
        exp_cnt++;
        read_ctrl();
        chk("R3 read hit when dir=1", {31'b0, hit_now()}, 32'h1);
    endtask

    task automatic t_burst();
        wr_ctrl(EN | DIR | NB | HIT | {exp_cnt, 16'h0});
        bus_op(A0, 1'b1, 1'b1);
        exp_cnt++;
        read_ctrl();
        chk("R4 burst ignored when nb=1", {31'b0, hit_now()}, 32'h0);
        bus_op(A0, 1'b1, 1'b0);
        exp_cnt++;
        read_ctrl();
        chk("R4 single hit when nb=1", {31'b0, hit_now()}, 32'h1);
    endtask

    task automatic t_addr();
        wr_ctrl(EN | DIR | NB | HIT | {exp_cnt, 16'h0});
        bus_op(A0 ^ 32'h8000_0000, 1'b1, 1'b0);
        exp_cnt++;
        read_ctrl();
        chk("R11 msb differs no hit", {31'b0, hit_now()}, 32'h0);
        bus_op(A0 ^ 32'h1, 1'b1, 1'b0);
        exp_cnt++;
        read_ctrl();
        chk("R11 lsb differs no hit", {31'b0, hit_now()}, 32'h0);
        snoop_valid = 1'b0; snoop_addr = A0; snoop_read = 1'b1; snoop_burst = 1'b0;
        step();
        read_ctrl();
        chk("R11 invalid no hit", {31'b0, hit_now()}, 32'h0);
        chk("R11 invalid no count", {16'b0, reg_rdata[31:16]}, {16'b0, exp_cnt});
    endtask

    task automatic t_irq();
        wr_ctrl(EN | DIR | NB | IE | {exp_cnt, 16'h0});
        chk("R8 irq low before hit", {31'b0, hwe_irq}, 32'h0);
        bus_op(A0, 1'b1, 1'b0);
        exp_cnt++;
        chk("R8 irq on hit", {31'b0, hwe_irq}, 32'h1);
        wr_ctrl(EN | DIR | NB | {exp_cnt, 16'h0});
        chk("R8 irq masked with hit set", {31'b0, hwe_irq}, 32'h0);
        wr_ctrl(EN | DIR | NB | IE | {exp_cnt, 16'h0});
        chk("R8 irq unmasked again", {31'b0, hwe_irq}, 32'h1);
        wr_ctrl(EN | DIR | NB | IE | HIT | {exp_cnt, 16'h0});
        chk("R8 irq drops on clear", {31'b0, hwe_irq}, 32'h0);
    endtask

    task automatic t_prio();
        bus_op(A0, 1'b1, 1'b0);
        exp_cnt++;
        reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = EN | DIR | NB | HIT | {exp_cnt, 16'h0};
        snoop_valid = 1'b1; snoop_addr = A0; snoop_read = 1'b1; snoop_burst = 1'b0;
        step();
        read_ctrl();
        chk("R7 set beats clear", {31'b0, hit_now()}, 32'h1);
    endtask

    task automatic t_disabled();
        wr_ctrl(DIR | NB | HIT | 32'h0042_0000);
        bus_op(A0, 1'b1, 1'b0);
        read_ctrl();
        chk("R5 no hit when disabled", {31'b0, hit_now()}, 32'h0);
        chk("R5 no count when disabled", {16'b0, reg_rdata[31:16]}, 32'h0042);
    endtask

    task automatic t_sat();
        wr_ctrl(EN | 32'hFFFE_0000);
        bus_op(32'h0, 1'b0, 1'b0);
        read_ctrl();
        chk("R9 count reaches max", {16'b0, reg_rdata[31:16]}, 32'hFFFF);
        bus_op(32'h0, 1'b0, 1'b0);
        bus_op(32'h0, 1'b0, 1'b0);
        read_ctrl();
        chk("R9 count saturates", {16'b0, reg_rdata[31:16]}, 32'hFFFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_basic();
        t_w1c();
        t_dir();
        t_burst();
        t_addr();
        t_irq();
        t_prio();
        t_disabled();
        t_sat();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule